// File: doc/BRIEF.md
# Three-Phase Gate-Drive Interlock

This block is the digital front end of a gate driver for a three-phase full bridge. Each of the U, V and W legs has one request for its high-side switch and one for its low-side switch. The block turns these six requests into six registered gate enables. It also takes an active-high enable, an under-voltage flag from a hysteretic supply comparator, and a supply-valid flag. From these it produces a single fault flag.

All five kinds of input pass through a two-flop synchronizer before any logic uses them. After that the block applies three gating conditions:

- An asserted enable lets the requests through.
- A low enable or a low supply-valid flag holds every gate off.
- A request for both switches of any one leg is a shoot-through request. It turns all six gates off, including those of the other legs, and raises fault.

Under-voltage raises the same fault flag but leaves switching untouched. Fault is not latched. It follows the current conditions through a register, so it cannot glitch.

Each gate waits a dead time of `DEAD_CYC` clock cycles before it turns on. The wait starts when the complementary gate of the same leg turns off. The block runs from one clock of 8 MHz, and the default of 8 cycles gives about 1 µs. Every pin is a plain level signal; there is no handshake.

Top module: `phase_gate_interlock`

## Requirements
- R1: While the synchronized enable is low, all six gates are low on the next clock. With no shoot-through request and no under-voltage, fault_o stays low.
- R2: With enable and supply-valid high and no shoot-through request, every gate follows its request, in the following cases:
  - from a long-idle state, a gate asserts on the third rising edge after its request changes;
  - any set of high sides passes through;
  - any set of low sides passes through;
  - a high side and a low side of different legs pass through together.
  Bit 0 of each bus is leg U, bit 1 is leg V and bit 2 is leg W.
- R3: When hi_req_i[k] and lo_req_i[k] are both high for some leg k, the following happens on the third rising edge: all six gates are low and fault_o is high.
- R4: Shoot-through fault is not latched. On the third rising edge after the conflicting pair goes away, fault_o is low and the remaining requests drive the gates again.
- R5: A high uv_i sets fault_o on the third rising edge, while the gates keep following the requests.
- R6: While supply_ok_i is low, all six gates are held low.
- R7: A gate turns on exactly DEAD_CYC clock cycles after the complementary gate of its leg turned off, and never sooner. After reset both gates of a leg count as off for long enough.
- R8: The two gates of one leg are never high together, and a gate drops on the clock after its synchronized request is withdrawn.
- R9: During and right after reset, all gates and fault_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8 MHz block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Drive enable, active high |
| uv_i | input | 1 | Under-voltage flag from the hysteretic comparator |
| supply_ok_i | input | 1 | Supply above minimum operating level |
| hi_req_i | input | NPH | High-side requests, bit 0 = U, 1 = V, 2 = W |
| lo_req_i | input | NPH | Low-side requests, same bit order |
| hi_gate_o | output | NPH | High-side gate enables |
| lo_gate_o | output | NPH | Low-side gate enables |
| fault_o | output | 1 | Registered fault: shoot-through request or under-voltage |

## Verification
The bench drives a same-leg pair while another leg is already conducting. A design that blanked only the offending leg would leave that other gate high. It then removes the pair and expects fault to fall with no other stimulus; a design that latched the fault would keep the bridge off. Under-voltage is applied while two legs conduct, so a design that gated outputs on under-voltage is exposed. A high-to-low leg handover is watched cycle by cycle: the bench checks that the gate comes on on exactly the expected edge and that the two gates of the leg never overlap. This catches both an off-by-one in the dead-time counter and a missing dead time.

// File: rtl/phase_intlk_pkg.sv
package phase_intlk_pkg;
  localparam int unsigned NPH = 3;

  function automatic logic any_leg_short(input logic [NPH-1:0] hs,
                                         input logic [NPH-1:0] ls);
    return |(hs & ls);
  endfunction
endpackage

// File: rtl/pgi_sync.sv
module pgi_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pgi_side.sv
// One switch of a leg: turns on only after the peer switch has been off
// for DEAD_CYC cycles; turns off on the clock after the request drops.
module pgi_side #(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic peer_on,
  output logic gate_o
);
  localparam int unsigned CW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

  logic [CW-1:0] off_cnt;
  logic          peer_quiet;

  assign peer_quiet = !peer_on && (off_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          off_cnt <= LAST;
    else if (peer_on)    off_cnt <= '0;
    else if (off_cnt != LAST) off_cnt <= off_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_o <= 1'b0;
    else        gate_o <= req && (gate_o || peer_quiet);
  end

  // independent window counter for the dead-time check
  localparam int unsigned QW = $clog2(DEAD_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(DEAD_CYC);
  logic [QW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         quiet <= QMAX;
    else if (peer_on)   quiet <= '0;
    else if (quiet != QMAX) quiet <= quiet + 1'b1;
  end

  p_dead_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (quiet >= QMAX));

  p_drop_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !gate_o);

  initial begin
    if (DEAD_CYC < 2) $error("DEAD_CYC must be at least 2");
  end
endmodule

// File: rtl/pgi_leg.sv
module pgi_leg #(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_gate_o,
  output logic lo_gate_o
);
  pgi_side #(.DEAD_CYC(DEAD_CYC)) u_hi (
    .clk(clk), .rst_n(rst_n), .req(hi_req), .peer_on(lo_gate_o), .gate_o(hi_gate_o)
  );

  pgi_side #(.DEAD_CYC(DEAD_CYC)) u_lo (
    .clk(clk), .rst_n(rst_n), .req(lo_req), .peer_on(hi_gate_o), .gate_o(lo_gate_o)
  );

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate_o && lo_gate_o));
endmodule

// File: rtl/phase_gate_interlock.sv
module phase_gate_interlock
  import phase_intlk_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           uv_i,
  input  logic           supply_ok_i,
  input  logic [NPH-1:0] hi_req_i,
  input  logic [NPH-1:0] lo_req_i,
  output logic [NPH-1:0] hi_gate_o,
  output logic [NPH-1:0] lo_gate_o,
  output logic           fault_o
);
  localparam int unsigned SW = 2 * NPH + 3;

  logic [SW-1:0]  sync_q;
  logic [NPH-1:0] hi_s, lo_s, hi_allow, lo_allow;
  logic           en_s, uv_s, sok_s, shoot, pass;

  pgi_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok_i, uv_i, en_i, lo_req_i, hi_req_i}),
    .q(sync_q)
  );

  assign {sok_s, uv_s, en_s, lo_s, hi_s} = sync_q;

  assign shoot    = any_leg_short(hi_s, lo_s);
  assign pass     = en_s && sok_s && !shoot;
  assign hi_allow = hi_s & {NPH{pass}};
  assign lo_allow = lo_s & {NPH{pass}};

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    pgi_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .hi_req(hi_allow[k]), .lo_req(lo_allow[k]),
      .hi_gate_o(hi_gate_o[k]), .lo_gate_o(lo_gate_o[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_o <= 1'b0;
    else        fault_o <= shoot || uv_s;
  end

  p_enable_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (hi_gate_o == '0) && (lo_gate_o == '0));

  p_supply_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sok_s |=> (hi_gate_o == '0) && (lo_gate_o == '0));

  p_shoot_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shoot |=> fault_o && (hi_gate_o == '0) && (lo_gate_o == '0));

  p_uv_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> fault_o);

  p_fault_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shoot && !uv_s) |=> !fault_o);
endmodule

// File: tb/phase_gate_interlock_bench.sv
module phase_gate_interlock_bench;
  localparam int unsigned DT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en, uv, sok;
  logic [2:0] hreq, lreq;
  logic [2:0] hgate, lgate;
  logic       fault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phase_gate_interlock #(.DEAD_CYC(DT)) u_phase_gate_interlock (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uv_i(uv), .supply_ok_i(sok),
    .hi_req_i(hreq), .lo_req_i(lreq),
    .hi_gate_o(hgate), .lo_gate_o(lgate), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] h, input logic [2:0] l,
                       input logic e, input logic u, input logic s);
    hreq = h; lreq = l; en = e; uv = u; sok = s;
  endtask

  task automatic idle();
    drive(3'b000, 3'b000, 1'b1, 1'b0, 1'b1);
    tick(DT + 6);
  endtask

  task automatic t_reset();
    chk("R9 gates in reset", {2'b0, hgate, lgate}, 8'h00);
    chk("R9 fault in reset", {7'b0, fault}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R9 gates after reset", {2'b0, hgate, lgate}, 8'h00);
    chk("R9 fault after reset", {7'b0, fault}, 8'h00);
  endtask

  task automatic t_enable();
    drive(3'b011, 3'b100, 1'b0, 1'b0, 1'b1);
    tick(DT + 4);
    chk("R1 enable low gates", {2'b0, hgate, lgate}, 8'h00);
    chk("R1 enable low fault", {7'b0, fault}, 8'h00);
  endtask

  task automatic t_pass();
    idle();
    drive(3'b001, 3'b000, 1'b1, 1'b0, 1'b1);
    tick(2);
    chk("R2 latency edge2", {5'b0, hgate}, 8'h00);
    tick(1);
    chk("R2 latency edge3", {5'b0, hgate}, 8'h01);
    drive(3'b111, 3'b000, 1'b1, 1'b0, 1'b1);
    tick(4);
    chk("R2 all high sides", {2'b0, hgate, lgate}, {2'b0, 3'b111, 3'b000});
    idle();
    drive(3'b000, 3'b111, 1'b1, 1'b0, 1'b1);
    tick(4);
    chk("R2 all low sides", {2'b0, hgate, lgate}, {2'b0, 3'b000, 3'b111});
    idle();
    drive(3'b001, 3'b010, 1'b1, 1'b0, 1'b1);
    tick(4);
    chk("R2 cross-leg pair", {2'b0, hgate, lgate}, {2'b0, 3'b001, 3'b010});
    chk("R2 cross-leg fault", {7'b0, fault}, 8'h00);
  endtask

  task automatic t_shoot();
    idle();
    drive(3'b010, 3'b000, 1'b1, 1'b0, 1'b1);
    tick(4);
    chk("R2 V high settled", {5'b0, hgate}, 8'h02);
    drive(3'b011, 3'b001, 1'b1, 1'b0, 1'b1);
    tick(2);
    chk("R3 before blank", {2'b0, hgate, lgate}, {2'b0, 3'b010, 3'b000});
    tick(1);
    chk("R3 all blanked", {2'b0, hgate, lgate}, 8'h00);
    chk("R3 fault raised", {7'b0, fault}, 8'h01);
    drive(3'b011, 3'b000, 1'b1, 1'b0, 1'b1);
    tick(3);
    chk("R4 fault cleared", {7'b0, fault}, 8'h00);
    chk("R4 resumed", {2'b0, hgate, lgate}, {2'b0, 3'b011, 3'b000});
  endtask

  task automatic t_uv();
    idle();
    drive(3'b100, 3'b010, 1'b1, 1'b0, 1'b1);
    tick(4);
    drive(3'b100, 3'b010, 1'b1, 1'b1, 1'b1);
    tick(3);
    chk("R5 uv fault", {7'b0, fault}, 8'h01);
    chk("R5 uv gates kept", {2'b0, hgate, lgate}, {2'b0, 3'b100, 3'b010});
    drive(3'b100, 3'b010, 1'b1, 1'b0, 1'b1);
    tick(3);
    chk("R5 uv released", {7'b0, fault}, 8'h00);
  endtask

  task automatic t_supply();
    idle();
    drive(3'b101, 3'b010, 1'b1, 1'b0, 1'b1);
    tick(4);
    drive(3'b101, 3'b010, 1'b1, 1'b0, 1'b0);
    tick(3);
    chk("R6 supply low gates", {2'b0, hgate, lgate}, 8'h00);
    chk("R6 supply low fault", {7'b0, fault}, 8'h00);
  endtask

  task automatic t_dead();
    idle();
    drive(3'b000, 3'b100, 1'b1, 1'b0, 1'b1);
    tick(DT + 4);
    chk("R7 W low settled", {5'b0, lgate}, 8'h04);
    drive(3'b100, 3'b000, 1'b1, 1'b0, 1'b1);
    for (int k = 1; k <= 3 + int'(DT); k++) begin
      tick(1);
      if ((hgate & lgate) != 3'b000) begin
        errors++;
        $display("FAIL R8 overlap actual=%0h expected=0", hgate & lgate);
      end
      if (k == 3) chk("R8 low drops", {5'b0, lgate}, 8'h00);
      if (k == 2 + int'(DT)) chk("R7 still in dead time", {5'b0, hgate}, 8'h00);
      if (k == 3 + int'(DT)) chk("R7 on after dead time", {5'b0, hgate}, 8'h04);
    end
    checks++;
  endtask

  initial begin
    drive(3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
    tick(3);
    t_reset();
    t_enable();
    t_pass();
    t_shoot();
    t_uv();
    t_supply();
    t_dead();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule